// File: doc/BRIEF.md
# Fetch PC Sequencer

This block holds the fetch program-counter state of an instruction fetch front end. It keeps three address entries in a chain: current, next and next-next. Each entry has an address, a valid bit, a delay-slot-taken flag and a per-lane instruction enable mask.

The current entry drives the cache request. The next entry goes to the branch predictor as its current PC, and the current entry goes along as the previous PC. The predicted next PC comes back into the next-next entry. When the current slot is empty and the two entries behind it are full, the chain advances by one. A redirect event reloads the chain with one or two addresses and overrides every other update in its cycle.

Top module: `fpc_seq`

## Requirements
- R1: After reset the cache request valid is low, and both the predictor request valid and the event acknowledge are high. The predictor request then carries the reset PC as its current PC, with the delay-slot-taken flag clear. The lane enable output is 1 (only bit 0, lane 0, set).
- R2: The predictor request presents the current entry's address as the previous PC. It presents the next entry's address and delay-slot-taken flag as the current PC and its flag.
- R3: The predictor request valid is high exactly when the next entry is valid and the next-next entry is invalid. On a completed predictor handshake, the returned PC, flag and mask fill the next-next entry and mark it valid. An acknowledge given while the request valid is low changes nothing.
- R4: When the current entry is invalid, after any cache handshake in that cycle, and the next and next-next entries are both valid, the chain advances by one. Each address, flag and mask moves with its entry, and next-next becomes invalid. A predictor result written in the same cycle counts as a valid next-next for this rule.
- R5: The cache request address, flag and lane enables come from the current entry, and the cache request valid equals its valid bit. A completed cache handshake invalidates the current entry.
- R6: An event invalidates the current entry. It loads the next entry with the event address and the event delay-slot-taken flag, and marks it valid.
- R7: An event loads the next-next entry with the event's second address. The entry's valid bit follows the second-address-valid input, and its flag is cleared.
- R8: An event sets the enable mask of every entry to lane 0 only.
- R9: An event overrides a predictor handshake and a cache handshake in the same cycle. The predictor result is discarded and the chain does not advance in that cycle.
- R10: The event acknowledge is high in every cycle out of reset.
- R11: With no handshake and no event, and no advance due, all outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cache_req_val_o | output | 1 | Cache request valid |
| cache_req_ack_i | input | 1 | Cache request accepted |
| cache_req_addr_o | output | AW | Fetch address (current entry) |
| cache_req_ds_o | output | 1 | Current entry delay-slot-taken flag |
| cache_req_lane_en_o | output | LANES | Current entry lane enables |
| pred_val_o | output | 1 | Predictor request valid |
| pred_ack_i | input | 1 | Predictor request accepted |
| pred_pc_prev_o | output | AW | Previous PC (current entry) |
| pred_pc_cur_o | output | AW | Current PC (next entry) |
| pred_pc_cur_ds_o | output | 1 | Next entry delay-slot-taken flag |
| pred_pc_next_i | input | AW | Predicted next PC |
| pred_pc_next_ds_i | input | 1 | Predicted PC delay-slot-taken flag |
| pred_lane_en_i | input | LANES | Predicted lane enables |
| evt_val_i | input | 1 | Redirect event valid |
| evt_ack_o | output | 1 | Redirect event accepted |
| evt_addr_i | input | AW | Event first address |
| evt_ds_i | input | 1 | Event first address delay-slot-taken flag |
| evt_addr2_i | input | AW | Event second address |
| evt_addr2_val_i | input | 1 | Event second address valid |

## Verification
A wrong valid bit shows up in the first cycle after the edge that sets it. A current-entry valid error shows on the cache request valid. A next or next-next valid error shows on the predictor request valid, because that signal depends on both entries. A wrong shift or a wrong event load shows on the predictor current PC and the cache address in that same cycle. A mask that fails to move with its entry stays hidden until the entry reaches the current slot, which is at most two advances later. The test sequence therefore drives each mask pattern all the way to the cache side.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_SHIFT = 2'd1,
    ACT_EVT   = 2'd2
  } chain_act_e;
endpackage

// File: rtl/fpc_entry.sv
module fpc_entry #(
  parameter int unsigned AW       = 32,
  parameter int unsigned LANES    = 4,
  parameter logic [AW-1:0] RST_ADDR = '0,
  parameter bit          RST_V    = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic             kill_i,
  input  logic [AW-1:0]    d_addr_i,
  input  logic             d_v_i,
  input  logic             d_ds_i,
  input  logic [LANES-1:0] d_mask_i,
  output logic [AW-1:0]    q_addr_o,
  output logic             q_v_o,
  output logic             q_ds_o,
  output logic [LANES-1:0] q_mask_o
);
  localparam logic [LANES-1:0] LANE0 = LANES'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_addr_o <= RST_ADDR;
      q_v_o    <= RST_V;
      q_ds_o   <= 1'b0;
      q_mask_o <= LANE0;
    end else if (ld_i) begin
      q_addr_o <= d_addr_i;
      q_v_o    <= d_v_i;
      q_ds_o   <= d_ds_i;
      q_mask_o <= d_mask_i;
    end else if (kill_i) begin
      q_v_o    <= 1'b0;
    end
  end
endmodule

// File: rtl/fpc_ctrl.sv
module fpc_ctrl
  import fpc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cur_v_i,
  input  logic       nxt_v_i,
  input  logic       nn_v_i,
  input  logic       cache_ack_i,
  input  logic       pred_ack_i,
  input  logic       evt_val_i,
  output logic       cache_val_o,
  output logic       pred_val_o,
  output logic       cache_fire_o,
  output logic       pred_fire_o,
  output chain_act_e act_o
);
  logic cur_after_v, nn_after_v;

  assign cache_val_o  = cur_v_i;
  assign pred_val_o   = nxt_v_i & ~nn_v_i;
  assign cache_fire_o = cache_val_o & cache_ack_i;
  assign pred_fire_o  = pred_val_o & pred_ack_i;

  assign cur_after_v = cur_v_i & ~cache_fire_o;
  assign nn_after_v  = nn_v_i | pred_fire_o;

  always_comb begin
    act_o = ACT_HOLD;
    if (evt_val_i)                                 act_o = ACT_EVT;
    else if (!cur_after_v && nxt_v_i && nn_after_v) act_o = ACT_SHIFT;
  end

  // an unaccepted predictor request stays posted
  p_pred_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pred_val_o && !pred_ack_i && !evt_val_i) |=> pred_val_o);

  // event leaves the current slot empty
  p_evt_kill_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_val_i |=> !cur_v_i);
endmodule

// File: rtl/fpc_seq.sv
module fpc_seq
  import fpc_pkg::*;
#(
  parameter int unsigned   AW       = 32,
  parameter int unsigned   LANES    = 4,
  parameter logic [AW-1:0] RESET_PC = 32'h0000_0100
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic             cache_req_val_o,
  input  logic             cache_req_ack_i,
  output logic [AW-1:0]    cache_req_addr_o,
  output logic             cache_req_ds_o,
  output logic [LANES-1:0] cache_req_lane_en_o,
  output logic             pred_val_o,
  input  logic             pred_ack_i,
  output logic [AW-1:0]    pred_pc_prev_o,
  output logic [AW-1:0]    pred_pc_cur_o,
  output logic             pred_pc_cur_ds_o,
  input  logic [AW-1:0]    pred_pc_next_i,
  input  logic             pred_pc_next_ds_i,
  input  logic [LANES-1:0] pred_lane_en_i,
  input  logic             evt_val_i,
  output logic             evt_ack_o,
  input  logic [AW-1:0]    evt_addr_i,
  input  logic             evt_ds_i,
  input  logic [AW-1:0]    evt_addr2_i,
  input  logic             evt_addr2_val_i
);
  localparam logic [LANES-1:0] LANE0 = LANES'(1);

  logic [AW-1:0]    cur_addr, nxt_addr, nn_addr;
  logic             cur_v, nxt_v, nn_v;
  logic             cur_ds, nxt_ds, nn_ds;
  logic [LANES-1:0] cur_mask, nxt_mask, nn_mask;

  logic             cache_fire, pred_fire;
  chain_act_e       act;

  // next-next as seen after this cycle's predictor write
  logic [AW-1:0]    nna_addr;
  logic             nna_ds;
  logic [LANES-1:0] nna_mask;

  logic             cur_ld, nxt_ld, nn_ld, cur_kill, nn_kill;
  logic [AW-1:0]    cur_d_addr, nxt_d_addr, nn_d_addr;
  logic             cur_d_v, nxt_d_v, nn_d_v;
  logic             cur_d_ds, nxt_d_ds, nn_d_ds;
  logic [LANES-1:0] cur_d_mask, nxt_d_mask, nn_d_mask;

  fpc_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cur_v_i     (cur_v),
    .nxt_v_i     (nxt_v),
    .nn_v_i      (nn_v),
    .cache_ack_i (cache_req_ack_i),
    .pred_ack_i  (pred_ack_i),
    .evt_val_i   (evt_val_i),
    .cache_val_o (cache_req_val_o),
    .pred_val_o  (pred_val_o),
    .cache_fire_o(cache_fire),
    .pred_fire_o (pred_fire),
    .act_o       (act)
  );

  assign nna_addr = pred_fire ? pred_pc_next_i    : nn_addr;
  assign nna_ds   = pred_fire ? pred_pc_next_ds_i : nn_ds;
  assign nna_mask = pred_fire ? pred_lane_en_i    : nn_mask;

  always_comb begin
    cur_ld = 1'b0; cur_kill = 1'b0;
    cur_d_addr = cur_addr; cur_d_v = cur_v; cur_d_ds = cur_ds; cur_d_mask = cur_mask;
    nxt_ld = 1'b0;
    nxt_d_addr = nxt_addr; nxt_d_v = nxt_v; nxt_d_ds = nxt_ds; nxt_d_mask = nxt_mask;
    nn_ld = 1'b0; nn_kill = 1'b0;
    nn_d_addr = nn_addr; nn_d_v = nn_v; nn_d_ds = nn_ds; nn_d_mask = nn_mask;
    unique case (act)
      ACT_EVT: begin
        cur_ld = 1'b1;
        cur_d_v = 1'b0; cur_d_mask = LANE0;
        nxt_ld = 1'b1;
        nxt_d_addr = evt_addr_i; nxt_d_v = 1'b1; nxt_d_ds = evt_ds_i; nxt_d_mask = LANE0;
        nn_ld = 1'b1;
        nn_d_addr = evt_addr2_i; nn_d_v = evt_addr2_val_i; nn_d_ds = 1'b0; nn_d_mask = LANE0;
      end
      ACT_SHIFT: begin
        cur_ld = 1'b1;
        cur_d_addr = nxt_addr; cur_d_v = 1'b1; cur_d_ds = nxt_ds; cur_d_mask = nxt_mask;
        nxt_ld = 1'b1;
        nxt_d_addr = nna_addr; nxt_d_v = 1'b1; nxt_d_ds = nna_ds; nxt_d_mask = nna_mask;
        nn_kill = 1'b1;
      end
      default: begin
        cur_kill = cache_fire;
        if (pred_fire) begin
          nn_ld = 1'b1;
          nn_d_addr = nna_addr; nn_d_v = 1'b1; nn_d_ds = nna_ds; nn_d_mask = nna_mask;
        end
      end
    endcase
  end

  fpc_entry #(.AW(AW), .LANES(LANES), .RST_ADDR('0), .RST_V(1'b0)) u_cur (
    .clk_i(clk_i), .rst_ni(rst_ni), .ld_i(cur_ld), .kill_i(cur_kill),
    .d_addr_i(cur_d_addr), .d_v_i(cur_d_v), .d_ds_i(cur_d_ds), .d_mask_i(cur_d_mask),
    .q_addr_o(cur_addr), .q_v_o(cur_v), .q_ds_o(cur_ds), .q_mask_o(cur_mask));

  fpc_entry #(.AW(AW), .LANES(LANES), .RST_ADDR(RESET_PC), .RST_V(1'b1)) u_nxt (
    .clk_i(clk_i), .rst_ni(rst_ni), .ld_i(nxt_ld), .kill_i(1'b0),
    .d_addr_i(nxt_d_addr), .d_v_i(nxt_d_v), .d_ds_i(nxt_d_ds), .d_mask_i(nxt_d_mask),
    .q_addr_o(nxt_addr), .q_v_o(nxt_v), .q_ds_o(nxt_ds), .q_mask_o(nxt_mask));

  fpc_entry #(.AW(AW), .LANES(LANES), .RST_ADDR('0), .RST_V(1'b0)) u_nn (
    .clk_i(clk_i), .rst_ni(rst_ni), .ld_i(nn_ld), .kill_i(nn_kill),
    .d_addr_i(nn_d_addr), .d_v_i(nn_d_v), .d_ds_i(nn_d_ds), .d_mask_i(nn_d_mask),
    .q_addr_o(nn_addr), .q_v_o(nn_v), .q_ds_o(nn_ds), .q_mask_o(nn_mask));

  assign cache_req_addr_o    = cur_addr;
  assign cache_req_ds_o      = cur_ds;
  assign cache_req_lane_en_o = cur_mask;
  assign pred_pc_prev_o      = cur_addr;
  assign pred_pc_cur_o       = nxt_addr;
  assign pred_pc_cur_ds_o    = nxt_ds;
  assign evt_ack_o           = rst_ni;

  p_shift_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cur_v && nxt_v && nn_v && !evt_val_i) |=> (cur_v && cur_addr == $past(nxt_addr)));

  p_cache_stall_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cache_req_val_o && !cache_req_ack_i && !evt_val_i) |=> (cache_req_val_o && $stable(cache_req_addr_o)));

  p_evt_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_val_i |=> (pred_pc_cur_o == $past(evt_addr_i) && pred_pc_cur_ds_o == $past(evt_ds_i)));

  p_evt_mask_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_val_i |=> (cache_req_lane_en_o == LANE0));
endmodule

// File: tb/fpc_seq_test.sv
module fpc_seq_test;
  localparam int AW = 32;
  localparam int LN = 4;
  localparam int NV = 13;

  typedef struct packed {
    logic          cack;
    logic          pack;
    logic [31:0]   pnext;
    logic          pds;
    logic [3:0]    pmask;
    logic          ev;
    logic [31:0]   eaddr;
    logic          eds;
    logic [31:0]   eaddr2;
    logic          ea2v;
    logic          x_cv;
    logic [31:0]   x_ca;
    logic          x_cds;
    logic [3:0]    x_lane;
    logic          x_pv;
    logic [31:0]   x_prev;
    logic [31:0]   x_pcur;
    logic          x_pcds;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b1,32'h104,1'b0,4'b0011, 1'b0,32'h0,1'b0,32'h0,1'b0, 1'b1,32'h100,1'b0,4'b0001, 1'b1,32'h100,32'h104,1'b0},
    '{1'b0,1'b0,32'h0,1'b0,4'b0000,   1'b0,32'h0,1'b0,32'h0,1'b0, 1'b1,32'h100,1'b0,4'b0001, 1'b1,32'h100,32'h104,1'b0},
    '{1'b1,1'b1,32'h200,1'b1,4'b1111, 1'b0,32'h0,1'b0,32'h0,1'b0, 1'b1,32'h104,1'b0,4'b0011, 1'b1,32'h104,32'h200,1'b1},
    '{1'b1,1'b0,32'h0,1'b0,4'b0000,   1'b0,32'h0,1'b0,32'h0,1'b0, 1'b0,32'h104,1'b0,4'b0011, 1'b1,32'h104,32'h200,1'b1},
    '{1'b0,1'b1,32'h208,1'b0,4'b0111, 1'b0,32'h0,1'b0,32'h0,1'b0, 1'b1,32'h200,1'b1,4'b1111, 1'b1,32'h200,32'h208,1'b0},
    '{1'b0,1'b1,32'h20C,1'b0,4'b0001, 1'b0,32'h0,1'b0,32'h0,1'b0, 1'b1,32'h200,1'b1,4'b1111, 1'b0,32'h200,32'h208,1'b0},
    '{1'b0,1'b1,32'h999,1'b1,4'b1000, 1'b0,32'h0,1'b0,32'h0,1'b0, 1'b1,32'h200,1'b1,4'b1111, 1'b0,32'h200,32'h208,1'b0},
    '{1'b1,1'b0,32'h0,1'b0,4'b0000,   1'b0,32'h0,1'b0,32'h0,1'b0, 1'b1,32'h208,1'b0,4'b0111, 1'b1,32'h208,32'h20C,1'b0},
    '{1'b1,1'b1,32'h500,1'b1,4'b1111, 1'b1,32'h400,1'b1,32'h404,1'b1, 1'b0,32'h208,1'b0,4'b0001, 1'b0,32'h208,32'h400,1'b1},
    '{1'b0,1'b0,32'h0,1'b0,4'b0000,   1'b0,32'h0,1'b0,32'h0,1'b0, 1'b1,32'h400,1'b1,4'b0001, 1'b1,32'h400,32'h404,1'b0},
    '{1'b0,1'b0,32'h0,1'b0,4'b0000,   1'b1,32'h800,1'b0,32'h804,1'b0, 1'b0,32'h400,1'b1,4'b0001, 1'b1,32'h400,32'h800,1'b0},
    '{1'b0,1'b0,32'h0,1'b0,4'b0000,   1'b0,32'h0,1'b0,32'h0,1'b0, 1'b0,32'h400,1'b1,4'b0001, 1'b1,32'h400,32'h800,1'b0},
    '{1'b0,1'b1,32'h810,1'b0,4'b0011, 1'b0,32'h0,1'b0,32'h0,1'b0, 1'b1,32'h800,1'b0,4'b0001, 1'b1,32'h800,32'h810,1'b0}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cack, pack, pds, ev, eds, ea2v;
  logic [AW-1:0] pnext, eaddr, eaddr2;
  logic [LN-1:0] pmask;
  logic          cv, cds, pv, pcds, eack;
  logic [AW-1:0] ca, prev, pcur;
  logic [LN-1:0] lane;
  int            checks = 0;
  int            failures = 0;

  always #5 clk = ~clk;

  fpc_seq #(.AW(AW), .LANES(LN), .RESET_PC(32'h100)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cache_req_val_o(cv), .cache_req_ack_i(cack), .cache_req_addr_o(ca),
    .cache_req_ds_o(cds), .cache_req_lane_en_o(lane),
    .pred_val_o(pv), .pred_ack_i(pack), .pred_pc_prev_o(prev), .pred_pc_cur_o(pcur),
    .pred_pc_cur_ds_o(pcds), .pred_pc_next_i(pnext), .pred_pc_next_ds_i(pds),
    .pred_lane_en_i(pmask),
    .evt_val_i(ev), .evt_ack_o(eack), .evt_addr_i(eaddr), .evt_ds_i(eds),
    .evt_addr2_i(eaddr2), .evt_addr2_val_i(ea2v)
  );

  function automatic string vtag(int i);
    case (i)
      0: return "R3 R4 pred fill and advance";
      1: return "R11 stall hold";
      2: return "R5 R4 cache fire with advance";
      3: return "R5 cache fire empties current";
      4: return "R4 R2 advance with mask";
      5: return "R3 pred fill no advance";
      6: return "R3 ack ignored while val low";
      7: return "R4 R5 advance after cache fire";
      8: return "R9 R6 R7 R8 event priority";
      9: return "R4 R8 advance after event";
      10: return "R7 R6 event second addr invalid";
      11: return "R7 R11 no advance without next-next";
      12: return "R3 R4 refill after event";
      default: return "?";
    endcase
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    cack = 0; pack = 0; pnext = '0; pds = 0; pmask = '0;
    ev = 0; eaddr = '0; eds = 0; eaddr2 = '0; ea2v = 0;
  endtask

  task automatic check_reset(string tag);
    chk({tag, " cache val"}, 64'(cv), 64'd0);
    chk({tag, " pred val"}, 64'(pv), 64'd1);
    chk({tag, " evt ack R10"}, 64'(eack), 64'd1);
    chk({tag, " pred cur pc"}, 64'(pcur), 64'h100);
    chk({tag, " pred cur ds"}, 64'(pcds), 64'd0);
    chk({tag, " lane en"}, 64'(lane), 64'd1);
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_reset("R1 reset");

    for (int i = 0; i < NV; i++) begin
      cack = VEC[i].cack; pack = VEC[i].pack; pnext = VEC[i].pnext;
      pds = VEC[i].pds; pmask = VEC[i].pmask; ev = VEC[i].ev;
      eaddr = VEC[i].eaddr; eds = VEC[i].eds; eaddr2 = VEC[i].eaddr2; ea2v = VEC[i].ea2v;
      @(negedge clk);
      chk({vtag(i), " cache val"},  64'(cv),   64'(VEC[i].x_cv));
      chk({vtag(i), " cache addr"}, 64'(ca),   64'(VEC[i].x_ca));
      chk({vtag(i), " cache ds"},   64'(cds),  64'(VEC[i].x_cds));
      chk({vtag(i), " lane en"},    64'(lane), 64'(VEC[i].x_lane));
      chk({vtag(i), " pred val"},   64'(pv),   64'(VEC[i].x_pv));
      chk({vtag(i), " R2 prev pc"}, 64'(prev), 64'(VEC[i].x_prev));
      chk({vtag(i), " R2 cur pc"},  64'(pcur), 64'(VEC[i].x_pcur));
      chk({vtag(i), " R2 cur ds"},  64'(pcds), 64'(VEC[i].x_pcds));
      chk({vtag(i), " R10 evt ack"}, 64'(eack), 64'd1);
    end

    // R11: hold over several idle cycles with a valid current entry
    idle();
    repeat (4) @(negedge clk);
    chk("R11 hold cache val", 64'(cv), 64'd1);
    chk("R11 hold cache addr", 64'(ca), 64'h800);
    chk("R11 hold pred cur", 64'(pcur), 64'h810);

    // R1: reset mid-run restores the reset state
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_reset("R1 re-reset");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule